// File: doc/BRIEF.md
# JTAG Pin Assignment Finder

This block hunts for the debug-port wiring on four unidentified pins of a board. It tries every way of giving the four pins the roles of test clock, mode select, data in and data out. For each candidate wiring it first walks the far-end TAP controller into its reset state. It then scans an all-ones instruction into the instruction register, which selects the one-bit bypass register. Finally it shifts a short probe word through the data path and watches the assumed data-out pin for the probe's echo.

A trial passes only when the single zero in the probe comes back exactly one test clock after it went in, with ones on both sides of it. A pin that is stuck high, stuck low, or not connected therefore never passes. The first wiring that passes stops the search. Its index and the four pin roles are then reported. If all 24 wirings fail, a not-found flag is raised instead. The test clock comes from a programmable divider of the system clock. Pins that are not being driven are left in high impedance.

Top module: `jtag_pin_finder`

## Requirements
- R1: After reset, and before the first start, found_o and none_o are low and pin_oe_o is 4'b0000.
- R2: The test clock toggles every div_i+1 system clock cycles, so one period is 2*(div_i+1) cycles. Mode select and data in change only when the test clock falls. Data out is sampled when it rises. div_i must be at least 2.
- R3: Every trial opens with RST_CYC (default 5) test-clock cycles with mode select high. This forces the target into its logic-reset state.
- R4: After the reset cycles, mode select follows 0,1,1,0,0 to enter instruction shift. It then stays low for IR_MAX (default 8) shift cycles with data in high, and goes high on the last of them. It then follows 1,1,0,0 to enter data shift.
- R5: The data phase has DATA_LEN (default 8) cycles with mode select low. Data in is 1 in every cycle except index ZERO_IDX (default 3), where it is 0. A trial passes only if the data-out sample taken at the rise of each data cycle d, for d from 1 to DATA_LEN-1, equals the data-in bit of cycle d-1.
- R6: Wirings are tried in index order 0 to 23, which is lexicographic order of the pin numbers for (clock, select, data in, data out). Index 0 is (0,1,2,3), index 17 is (2,3,1,0) and index 23 is (3,2,1,0). The index moves forward only by one.
- R7: During a trial, exactly the clock, select and data-in pins of the current wiring are driven, and the data-out pin floats. When no search is running, all pins float.
- R8: At the falling edge that ends the first passing trial k, found_o goes high. This is (k+1)*2*STEPS*(div_i+1) cycles after the edge that accepted start_i, where STEPS = RST_CYC+IR_MAX+DATA_LEN+9. perm_o and the four role outputs then hold that wiring until the next start, and the next start clears found_o.
- R9: If all 24 trials fail, none_o goes high at the end of the last trial and found_o stays low.
- R10: A data-out pin that is stuck high (floating with a pull-up) or stuck low never produces a pass.
- R11: start_i is ignored while a search is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins a search when idle |
| div_i | input | DIV_W | Test-clock half period minus one, in system cycles (>= 2) |
| pin_i | input | 4 | Levels read back from the candidate pins |
| pin_o | output | 4 | Levels driven onto the candidate pins |
| pin_oe_o | output | 4 | Drive enable per pin; low means high impedance |
| found_o | output | 1 | A wiring passed the echo test |
| none_o | output | 1 | All wirings failed |
| perm_o | output | 5 | Index of the current or winning wiring |
| tck_pin_o | output | 2 | Pin number of the test clock in that wiring |
| tms_pin_o | output | 2 | Pin number of the mode select |
| tdi_pin_o | output | 2 | Pin number of the data in |
| tdo_pin_o | output | 2 | Pin number of the data out |

## Verification
Each result has a fixed due time: trial k ends (k+1)*2*STEPS*(div_i+1) cycles after the edge that accepts start_i. The bench counts falling system-clock edges from that point and requires found_o or none_o to appear on exactly that count. The mode-select and data-in levels, and the test-clock period, are captured at each rising edge of the driven clock pin. These captures take place well after the falling edge at which the levels last changed. Pin enables are checked at a falling system-clock edge inside the first trial and again after the search has finished. A behavioural target TAP echoes the data through its bypass register only when every pin role matches the true wiring.

// File: rtl/jpf_pkg.sv
package jpf_pkg;
  localparam int unsigned NPINS  = 4;
  localparam int unsigned NPERMS = 24;
  localparam int unsigned PERM_W = $clog2(NPERMS);

  typedef logic [1:0] pin_t;

  typedef struct packed {
    pin_t tdo;
    pin_t tdi;
    pin_t tms;
    pin_t tck;
  } roles_t;

  // lexicographic rank -> (tck, tms, tdi, tdo) pin numbers
  function automatic roles_t perm_decode(input logic [PERM_W-1:0] idx);
    roles_t      r;
    logic [3:0]  used;
    int unsigned rank [3];
    int unsigned sel  [3];
    int unsigned n;
    int unsigned last;
    rank[0] = int'(idx) / 6;
    rank[1] = (int'(idx) % 6) / 2;
    rank[2] = int'(idx) % 2;
    used = '0;
    last = 0;
    for (int k = 0; k < 3; k++) begin
      n      = 0;
      sel[k] = 0;
      for (int p = 0; p < 4; p++) begin
        if (!used[p]) begin
          if (n == rank[k]) sel[k] = p;
          n++;
        end
      end
      used[sel[k]] = 1'b1;
    end
    for (int p = 0; p < 4; p++) if (!used[p]) last = p;
    r.tck = pin_t'(sel[0]);
    r.tms = pin_t'(sel[1]);
    r.tdi = pin_t'(sel[2]);
    r.tdo = pin_t'(last);
    return r;
  endfunction
endpackage

// File: rtl/jpf_tck_gen.sv
module jpf_tck_gen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tck_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             tck_q;
  logic             hit;

  assign hit = en_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tck_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      tck_q <= 1'b0;
    end else if (hit) begin
      cnt_q <= '0;
      tck_q <= ~tck_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tck_o  = tck_q;
  assign rise_o = hit && !tck_q;
  assign fall_o = hit && tck_q;

  AST_TCK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && cnt_q != '0) |-> $stable(tck_q)); // R2
  AST_TCK_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !$past(en_i)) |-> !tck_q); // R2
endmodule

// File: rtl/jpf_seq.sv
module jpf_seq
  import jpf_pkg::*;
#(
  parameter int unsigned RST_CYC  = 5,
  parameter int unsigned IR_MAX   = 8,
  parameter int unsigned DATA_LEN = 8,
  parameter int unsigned ZERO_IDX = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              tdo_i,
  output logic              busy_o,
  output logic [PERM_W-1:0] perm_o,
  output logic              tms_o,
  output logic              tdi_o,
  output logic              found_o,
  output logic              none_o
);
  localparam int unsigned STEPS  = RST_CYC + IR_MAX + DATA_LEN + 9;
  localparam int unsigned STEP_W = $clog2(STEPS);
  localparam logic [STEP_W-1:0] S_RTI  = STEP_W'(RST_CYC);
  localparam logic [STEP_W-1:0] S_SDR  = STEP_W'(RST_CYC + 1);
  localparam logic [STEP_W-1:0] S_SIR  = STEP_W'(RST_CYC + 2);
  localparam logic [STEP_W-1:0] S_IRL  = STEP_W'(RST_CYC + 4 + IR_MAX);
  localparam logic [STEP_W-1:0] S_UIR  = STEP_W'(RST_CYC + 5 + IR_MAX);
  localparam logic [STEP_W-1:0] S_SDR2 = STEP_W'(RST_CYC + 6 + IR_MAX);
  localparam logic [STEP_W-1:0] S_DR0  = STEP_W'(RST_CYC + 9 + IR_MAX);
  localparam logic [STEP_W-1:0] S_LAST = STEP_W'(STEPS - 1);
  localparam logic [STEP_W-1:0] ZIDX   = STEP_W'(ZERO_IDX);
  localparam logic [PERM_W-1:0] P_LAST = PERM_W'(NPERMS - 1);

  logic              busy_q, err_q, found_q, none_q;
  logic [STEP_W-1:0] step_q;
  logic [PERM_W-1:0] perm_q;
  logic [STEP_W-1:0] data_idx;
  logic              in_data, in_check, exp_bit;

  assign data_idx = step_q - S_DR0;
  assign in_data  = (step_q >= S_DR0);
  assign in_check = (step_q > S_DR0);
  // the bit shifted in one clock earlier must come back now
  assign exp_bit  = ((data_idx - 1'b1) != ZIDX);

  always_comb begin
    tms_o = 1'b0;
    tdi_o = 1'b1;
    if (step_q < S_RTI)                                   tms_o = 1'b1;
    else if (step_q == S_SDR || step_q == S_SIR)          tms_o = 1'b1;
    else if (step_q == S_IRL || step_q == S_UIR
             || step_q == S_SDR2)                         tms_o = 1'b1;
    if (in_data && data_idx == ZIDX)                      tdi_o = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      err_q   <= 1'b0;
      found_q <= 1'b0;
      none_q  <= 1'b0;
      step_q  <= '0;
      perm_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q  <= 1'b1;
        err_q   <= 1'b0;
        found_q <= 1'b0;
        none_q  <= 1'b0;
        step_q  <= '0;
        perm_q  <= '0;
      end
    end else begin
      if (rise_i && in_check && (tdo_i != exp_bit)) err_q <= 1'b1;
      if (fall_i) begin
        if (step_q == S_LAST) begin
          step_q <= '0;
          err_q  <= 1'b0;
          if (!err_q) begin
            busy_q  <= 1'b0;
            found_q <= 1'b1;
          end else if (perm_q == P_LAST) begin
            busy_q <= 1'b0;
            none_q <= 1'b1;
          end else begin
            perm_q <= perm_q + 1'b1;
          end
        end else begin
          step_q <= step_q + 1'b1;
        end
      end
    end
  end

  assign busy_o  = busy_q;
  assign perm_o  = perm_q;
  assign found_o = found_q;
  assign none_o  = none_q;

  AST_STEP_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !fall_i) |=> (step_q == $past(step_q))); // R2
  AST_RESET_TMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && step_q < S_RTI) |-> tms_o); // R3
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i && !fall_i) |=> (perm_q == $past(perm_q) && busy_q)); // R11
endmodule

// File: rtl/jpf_pin_mux.sv
module jpf_pin_mux
  import jpf_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             busy_i,
  input  roles_t           roles_i,
  input  logic             tck_i,
  input  logic             tms_i,
  input  logic             tdi_i,
  input  logic [NPINS-1:0] pin_i,
  output logic [NPINS-1:0] pin_o,
  output logic [NPINS-1:0] pin_oe_o,
  output logic             tdo_o
);
  logic [NPINS-1:0] sync1_q, sync2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= '1;
      sync2_q <= '1;
    end else begin
      sync1_q <= pin_i;
      sync2_q <= sync1_q;
    end
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    always_comb begin
      if (roles_i.tck == pin_t'(p))      pin_o[p] = tck_i;
      else if (roles_i.tms == pin_t'(p)) pin_o[p] = tms_i;
      else                               pin_o[p] = tdi_i;
    end
    assign pin_oe_o[p] = busy_i && (roles_i.tdo != pin_t'(p));
  end

  assign tdo_o = sync2_q[roles_i.tdo];
endmodule

// File: rtl/jtag_pin_finder.sv
module jtag_pin_finder
  import jpf_pkg::*;
#(
  parameter int unsigned DIV_W    = 8,
  parameter int unsigned RST_CYC  = 5,
  parameter int unsigned IR_MAX   = 8,
  parameter int unsigned DATA_LEN = 8,
  parameter int unsigned ZERO_IDX = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [3:0]       pin_i,
  output logic [3:0]       pin_o,
  output logic [3:0]       pin_oe_o,
  output logic             found_o,
  output logic             none_o,
  output logic [4:0]       perm_o,
  output logic [1:0]       tck_pin_o,
  output logic [1:0]       tms_pin_o,
  output logic [1:0]       tdi_pin_o,
  output logic [1:0]       tdo_pin_o
);
  logic              busy, tck, rise, fall, tms, tdi, tdo;
  logic [PERM_W-1:0] perm;
  roles_t            roles;
  logic [3:0]        role_mask;

  jpf_tck_gen #(.DIV_W(DIV_W)) u_tck (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (busy),
    .div_i  (div_i),
    .tck_o  (tck),
    .rise_o (rise),
    .fall_o (fall)
  );

  jpf_seq #(
    .RST_CYC  (RST_CYC),
    .IR_MAX   (IR_MAX),
    .DATA_LEN (DATA_LEN),
    .ZERO_IDX (ZERO_IDX)
  ) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .rise_i  (rise),
    .fall_i  (fall),
    .tdo_i   (tdo),
    .busy_o  (busy),
    .perm_o  (perm),
    .tms_o   (tms),
    .tdi_o   (tdi),
    .found_o (found_o),
    .none_o  (none_o)
  );

  assign roles = perm_decode(perm);

  jpf_pin_mux u_mux (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .busy_i   (busy),
    .roles_i  (roles),
    .tck_i    (tck),
    .tms_i    (tms),
    .tdi_i    (tdi),
    .pin_i    (pin_i),
    .pin_o    (pin_o),
    .pin_oe_o (pin_oe_o),
    .tdo_o    (tdo)
  );

  assign perm_o    = perm;
  assign tck_pin_o = roles.tck;
  assign tms_pin_o = roles.tms;
  assign tdi_pin_o = roles.tdi;
  assign tdo_pin_o = roles.tdo;
  assign role_mask = (4'b0001 << roles.tck) | (4'b0001 << roles.tms)
                   | (4'b0001 << roles.tdi) | (4'b0001 << roles.tdo);

  AST_ROLES_DISTINCT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(role_mask) == 4); // R6
  AST_PERM_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy) && perm != $past(perm)) |-> (perm == $past(perm) + 1'b1)); // R6
  AST_IDLE_FLOAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> (pin_oe_o == 4'b0000)); // R7
  AST_TDO_FLOAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> ($countones(pin_oe_o) == 3 && !pin_oe_o[roles.tdo])); // R7
  AST_DONE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(found_o && none_o)); // R9
  AST_FOUND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (found_o && !start_i) |=> (found_o && $stable(perm))); // R8
endmodule

// File: tb/jtag_pin_finder_tb.sv
module jtag_pin_finder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int RST_CYC    = 5;
  localparam int IR_MAX     = 8;
  localparam int DATA_LEN   = 8;
  localparam int ZERO_IDX   = 3;
  localparam int STEPS      = RST_CYC + IR_MAX + DATA_LEN + 9;
  localparam int WD_LIMIT   = 150000;

  // TAP model states
  localparam logic [3:0] T_TLR = 0, T_RTI = 1, T_SDR = 2, T_CDR = 3, T_SHD = 4,
    T_E1D = 5, T_PD = 6, T_E2D = 7, T_UDR = 8, T_SIR = 9, T_CIR = 10,
    T_SHI = 11, T_E1I = 12, T_PI = 13, T_E2I = 14, T_UIR = 15;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] div = 8'd2;
  logic [3:0] pin_i, pin_o, pin_oe, drv;
  logic       found, none;
  logic [4:0] perm;
  logic [1:0] tck_pin, tms_pin, tdi_pin, tdo_pin;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  // target wiring and behaviour: mode 0 live TAP, 1 absent, 2 tdo stuck low
  logic [1:0] t_tck = 0, t_tms = 1, t_tdi = 2, t_tdo = 3;
  int         t_mode = 1;
  int         ir_len = 4;
  logic       tgt_tck, tgt_tms, tgt_tdi, tap_tdo;
  logic [3:0] st = T_TLR;
  logic [7:0] ir_sh = 8'h01, ir_act = 8'h00;
  logic       byp = 1'b0;
  logic [31:0] idr = '1;

  // trial-0 capture at rises of pin 0
  logic rec_on = 1'b0;
  int   rec_n  = 0;
  logic rec_tms [STEPS];
  logic rec_tdi [STEPS];
  int   rec_cyc [STEPS];
  logic exp_tms [STEPS];
  logic exp_tdi [STEPS];

  jtag_pin_finder #(
    .DIV_W(8), .RST_CYC(RST_CYC), .IR_MAX(IR_MAX),
    .DATA_LEN(DATA_LEN), .ZERO_IDX(ZERO_IDX)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .div_i(div),
    .pin_i(pin_i), .pin_o(pin_o), .pin_oe_o(pin_oe),
    .found_o(found), .none_o(none), .perm_o(perm),
    .tck_pin_o(tck_pin), .tms_pin_o(tms_pin),
    .tdi_pin_o(tdi_pin), .tdo_pin_o(tdo_pin)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) cyc++;

  assign drv     = (pin_oe & pin_o) | ~pin_oe;   // pull-ups on floating pins
  assign tgt_tck = drv[t_tck];
  assign tgt_tms = drv[t_tms];
  assign tgt_tdi = drv[t_tdi];

  always_comb begin
    pin_i = drv;
    if (t_mode == 0)      pin_i[t_tdo] = tap_tdo;
    else if (t_mode == 2) pin_i[t_tdo] = 1'b0;
  end

  always @(posedge tgt_tck) begin
    case (st)
      T_TLR: ir_act <= 8'h00;
      T_CIR: ir_sh  <= 8'h01;
      T_SHI: ir_sh  <= (ir_sh >> 1) | (8'(tgt_tdi) << (ir_len - 1));
      T_UIR: ir_act <= ir_sh;
      T_CDR: begin byp <= 1'b0; idr <= '1; end
      T_SHD: begin byp <= tgt_tdi; idr <= {tgt_tdi, idr[31:1]}; end
      default: ;
    endcase
    case (st)
      T_TLR: st <= tgt_tms ? T_TLR : T_RTI;
      T_RTI: st <= tgt_tms ? T_SDR : T_RTI;
      T_SDR: st <= tgt_tms ? T_SIR : T_CDR;
      T_CDR: st <= tgt_tms ? T_E1D : T_SHD;
      T_SHD: st <= tgt_tms ? T_E1D : T_SHD;
      T_E1D: st <= tgt_tms ? T_UDR : T_PD;
      T_PD:  st <= tgt_tms ? T_E2D : T_PD;
      T_E2D: st <= tgt_tms ? T_UDR : T_SHD;
      T_UDR: st <= tgt_tms ? T_SDR : T_RTI;
      T_SIR: st <= tgt_tms ? T_TLR : T_CIR;
      T_CIR: st <= tgt_tms ? T_E1I : T_SHI;
      T_SHI: st <= tgt_tms ? T_E1I : T_SHI;
      T_E1I: st <= tgt_tms ? T_UIR : T_PI;
      T_PI:  st <= tgt_tms ? T_E2I : T_PI;
      T_E2I: st <= tgt_tms ? T_UIR : T_SHI;
      default: st <= tgt_tms ? T_SDR : T_RTI;
    endcase
  end

  always @(negedge tgt_tck) begin
    if (st == T_SHI)      tap_tdo <= ir_sh[0];
    else if (st == T_SHD) tap_tdo <= (ir_act == (8'hFF >> (8 - ir_len))) ? byp : idr[0];
    else                  tap_tdo <= 1'b1;
  end

  always @(posedge drv[0]) begin
    if (rec_on && rec_n < STEPS) begin
      rec_tms[rec_n] = drv[1];
      rec_tdi[rec_n] = drv[2];
      rec_cyc[rec_n] = cyc;
      rec_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // lexicographic enumeration of (tck, tms, tdi, tdo)
  task automatic roles_of(input int idx, output int a, output int b,
                          output int c, output int d);
    int k = 0;
    a = 0; b = 0; c = 0; d = 0;
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        for (int m = 0; m < 4; m++)
          if (i != j && i != m && j != m) begin
            if (k == idx) begin a = i; b = j; c = m; d = 6 - i - j - m; end
            k++;
          end
  endtask

  task automatic set_target(input int idx, input int mode, input int irl);
    int a, b, c, d;
    roles_of(idx, a, b, c, d);
    t_tck = 2'(a); t_tms = 2'(b); t_tdi = 2'(c); t_tdo = 2'(d);
    t_mode = mode; ir_len = irl;
  endtask

  // start pulse, then count falling edges until a result
  task automatic run_search(input int d, input int pulse_at, output int n);
    @(negedge clk);
    div = 8'(d);
    rec_n = 0; rec_on = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    chk(!found && !none, "R8", "flags cleared by start", int'(found), 0);
    while (!(found || none) && n < 40000) begin
      @(negedge clk);
      n++;
      if (n == pulse_at) start = 1'b1;
      else start = 1'b0;
    end
    rec_on = 1'b0;
  endtask

  task automatic t_reset();
    chk(!found, "R1", "found_o after reset", int'(found), 0);
    chk(!none, "R1", "none_o after reset", int'(none), 0);
    chk(pin_oe == 4'b0000, "R1", "pin_oe_o after reset", int'(pin_oe), 0);
  endtask

  task automatic t_first_wiring();
    int n, bad_tms, bad_tdi;
    set_target(0, 0, 4);
    fork
      run_search(2, 0, n);
      begin
        repeat (6) @(negedge clk);
        chk(pin_oe == 4'b0111, "R7", "enables in trial 0", int'(pin_oe), 7);
      end
    join
    chk(found && !none, "R8", "found on wiring 0", int'(found), 1);
    chk(n == 2*STEPS*3 + 1, "R8", "result time k=0", n, 2*STEPS*3 + 1);
    chk(perm == 5'd0, "R6", "index of wiring 0", int'(perm), 0);
    chk(rec_n == STEPS, "R2", "clock rises in trial 0", rec_n, STEPS);
    chk(rec_cyc[1] - rec_cyc[0] == 6, "R2", "period at div 2",
        rec_cyc[1] - rec_cyc[0], 6);
    bad_tms = 0; bad_tdi = 0;
    for (int s = 0; s < STEPS; s++) begin
      if (rec_tms[s] !== exp_tms[s]) bad_tms++;
      if (rec_tdi[s] !== exp_tdi[s]) bad_tdi++;
    end
    chk(bad_tms == 0, "R3", "mode-select levels in reset phase and scans", bad_tms, 0);
    chk(bad_tms == 0, "R4", "mode-select walk to instruction/data shift", bad_tms, 0);
    chk(bad_tdi == 0, "R5", "data-in probe with one zero", bad_tdi, 0);
    chk(pin_oe == 4'b0000, "R7", "pins float after search", int'(pin_oe), 0);
    repeat (20) @(negedge clk);
    chk(found && perm == 5'd0, "R8", "result held", int'(perm), 0);
  endtask

  task automatic t_mid_wiring();
    int n, a, b, c, d;
    set_target(17, 0, 8);
    roles_of(17, a, b, c, d);
    run_search(3, 700, n);
    chk(found, "R11", "start during search ignored", int'(found), 1);
    chk(n == 18*2*STEPS*4 + 1, "R8", "result time k=17", n, 18*2*STEPS*4 + 1);
    chk(perm == 5'd17, "R6", "index of wiring 17", int'(perm), 17);
    chk(int'(tck_pin) == a && int'(tms_pin) == b, "R6", "clock/select roles",
        int'(tck_pin)*4 + int'(tms_pin), a*4 + b);
    chk(int'(tdi_pin) == c && int'(tdo_pin) == d, "R6", "data roles",
        int'(tdi_pin)*4 + int'(tdo_pin), c*4 + d);
    chk(rec_cyc[2] - rec_cyc[1] == 8, "R2", "period at div 3",
        rec_cyc[2] - rec_cyc[1], 8);
  endtask

  task automatic t_last_wiring();
    int n;
    set_target(23, 0, 8);
    run_search(2, 0, n);
    chk(found && perm == 5'd23, "R6", "last wiring found", int'(perm), 23);
    chk(tck_pin == 2'd3 && tdo_pin == 2'd0, "R6", "roles of wiring 23",
        int'(tck_pin)*4 + int'(tdo_pin), 12);
  endtask

  task automatic t_absent();
    int n;
    set_target(5, 1, 4);
    run_search(2, 0, n);
    chk(none && !found, "R9", "none_o with no target", int'(none), 1);
    chk(n == 24*2*STEPS*3 + 1, "R9", "none time", n, 24*2*STEPS*3 + 1);
    chk(!found, "R10", "floating data-out never passes", int'(found), 0);
  endtask

  task automatic t_stuck_low();
    int n;
    set_target(0, 2, 4);
    run_search(2, 0, n);
    chk(none && !found, "R10", "stuck-low data-out rejected", int'(found), 0);
    chk(pin_oe == 4'b0000, "R7", "pins float after none", int'(pin_oe), 0);
  endtask

  initial begin
    for (int s = 0; s < STEPS; s++) begin
      exp_tdi[s] = 1'b1;
      if (s < RST_CYC)                                exp_tms[s] = 1'b1;
      else if (s == RST_CYC + 1 || s == RST_CYC + 2)  exp_tms[s] = 1'b1;
      else if (s >= RST_CYC + 4 + IR_MAX && s <= RST_CYC + 6 + IR_MAX)
                                                       exp_tms[s] = 1'b1;
      else                                             exp_tms[s] = 1'b0;
      if (s == RST_CYC + 9 + IR_MAX + ZERO_IDX)        exp_tdi[s] = 1'b0;
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (cyc > WD_LIMIT) begin
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected below %0d", cyc, WD_LIMIT);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_first_wiring();
    t_mid_wiring();
    t_last_wiring();
    t_absent();
    t_stuck_low();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule